// File: doc/BRIEF.md
# Pause-Width Reader Bit Transmitter

This block sends a frame of reader-to-card bits on one modulation-control output. The value of each bit is given by how long it lasts. Every bit opens with a carrier-off gap of fixed length, during which the output is high. The output then goes low for the remainder of the bit period. A logic 1 and a logic 0 each have their own total period. No start or stop symbol surrounds the frame. Once the last bit is out, a single extra carrier-off gap closes the frame, and the output returns to its low idle level.

A host supplies a payload of up to `MAX_BITS` bits, a bit count, and three tick counts: the gap length, the period of a 1 and the period of a 0. It then pulses `start_i`. All of these values are captured in the cycle that start is accepted. Segment ends are scheduled against a free-running tick counter. Each new deadline is the previous deadline plus the length of the next segment, so rounding never accumulates across a long frame.

The control is a four-state machine:
- `ST_IDLE` is left on an accepted start. It goes to `ST_PAUSE` when at least one bit is to be sent, or directly to `ST_EOF` for an empty frame.
- `ST_PAUSE` moves to `ST_CARRIER` when the gap deadline is reached.
- `ST_CARRIER` moves back to `ST_PAUSE` while bits remain, and to `ST_EOF` after the last bit.
- `ST_EOF` returns to `ST_IDLE` when the closing gap ends, raising `done_o` for that one cycle.

Top module: `pause_bit_sender`

## Requirements
- R1: Out of reset, and at all times while idle, `pause_o`, `busy_o` and `done_o` are low.
- R2: A start sampled high at a clock edge while idle makes `pause_o` high from the next cycle for exactly `pause_ticks_i` cycles, with `busy_o` high.
- R3: After each bit's gap, `pause_o` is low for `one_ticks_i - pause_ticks_i` cycles when the bit is 1, or for `zero_ticks_i - pause_ticks_i` cycles when it is 0. Bits go out from bit 0 of `frame_i` upward.
- R4: Exactly `len_i` bits are sent, and payload bits at or above `len_i` have no effect on the output. A `len_i` above `MAX_BITS` sends `MAX_BITS` bits.
- R5: After the last bit, `pause_o` is high for `pause_ticks_i` more cycles, and then low.
- R6: With `len_i` equal to 0, the frame consists only of the closing gap of `pause_ticks_i` cycles.
- R7: `done_o` is high for exactly one cycle, the cycle right after the closing gap, and `busy_o` is low in that cycle. A start sampled in that cycle is accepted.
- R8: A start sampled while `busy_o` is high is ignored.
- R9: The payload, length and durations are captured at the accepted start. Changing them during a frame does not alter that frame.
- R10: Every segment has its exact programmed length, including frames that span the wrap of the internal tick counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| frame_i | input | MAX_BITS | Payload bits, bit 0 sent first |
| len_i | input | LEN_W | Number of bits to send |
| pause_ticks_i | input | CNT_W | Gap length in clock ticks (at least 1) |
| one_ticks_i | input | CNT_W | Total period of a 1 bit (greater than the gap) |
| zero_ticks_i | input | CNT_W | Total period of a 0 bit (greater than the gap) |
| pause_o | output | 1 | High = carrier off (gap), low = carrier on |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the closing gap |

## Verification
The hardest situation to reach from the ports is a frame that runs across the wrap of the internal absolute tick counter. Drift-free scheduling matters most there, because deadlines roll over while the time base also wraps. The stimulus idles until just before the counter width's worth of cycles has elapsed since reset. It then sends a run of long full-length frames with large durations, which is certain to straddle the wrap. Other hard cases are a start held high so that it lands in the done cycle, and inputs changed in the middle of a frame. Both are reached by driving the inputs at chosen cycle offsets after an accepted start.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PAUSE   = 2'd1,
        ST_CARRIER = 2'd2,
        ST_EOF     = 2'd3
    } pbs_state_t;

endpackage

// File: rtl/pbs_deadline_timer.sv
// Free-running time base with an absolute deadline register.
// arm_i places the deadline relative to the current time; adv_i moves it
// forward from the previous deadline so segment lengths never drift.
module pbs_deadline_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] dur_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] now_q;
    logic [CNT_W-1:0] due_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
            due_q <= '0;
        end else begin
            now_q <= now_q + 1'b1;
            if (arm_i) begin
                due_q <= now_q + dur_i;
            end else if (adv_i) begin
                due_q <= due_q + dur_i;
            end
        end
    end

    assign expired_o = (now_q == due_q);

endmodule

// File: rtl/pbs_frame_shifter.sv
// Holds the payload and remaining bit count; presents the current bit.
module pbs_frame_shifter #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [MAX_BITS-1:0] frame_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                pop_i,
    output logic                bit_o,
    output logic                more_o,
    output logic                load_empty_o
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BITS);

    logic [MAX_BITS-1:0] sr_q;
    logic [LEN_W-1:0]    rem_q;
    logic [LEN_W-1:0]    len_cl;

    assign len_cl = (len_i > LEN_CAP) ? LEN_CAP : len_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            rem_q <= '0;
        end else if (load_i) begin
            sr_q  <= frame_i;
            rem_q <= len_cl;
        end else if (pop_i) begin
            sr_q  <= sr_q >> 1;
            rem_q <= rem_q - 1'b1;
        end
    end

    assign bit_o        = sr_q[0];
    assign more_o       = (rem_q > LEN_W'(1));
    assign load_empty_o = (len_cl == '0);

endmodule

// File: rtl/pause_bit_sender.sv
module pause_bit_sender
    import pbs_pkg::*;
#(
    parameter  int MAX_BITS = 32,
    parameter  int CNT_W    = 16,
    localparam int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] frame_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic [CNT_W-1:0]    pause_ticks_i,
    input  logic [CNT_W-1:0]    one_ticks_i,
    input  logic [CNT_W-1:0]    zero_ticks_i,
    output logic                pause_o,
    output logic                busy_o,
    output logic                done_o
);

    pbs_state_t state_q, state_d;

    logic [CNT_W-1:0] gap_len_q;
    logic [CNT_W-1:0] one_rest_q;
    logic [CNT_W-1:0] zero_rest_q;

    logic             tmr_arm, tmr_adv, tmr_expired;
    logic [CNT_W-1:0] tmr_dur;
    logic             shf_load, shf_pop, shf_bit, shf_more, shf_load_empty;
    logic             done_d;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    pbs_deadline_timer #(.CNT_W(CNT_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (tmr_arm),
        .adv_i     (tmr_adv),
        .dur_i     (tmr_dur),
        .expired_o (tmr_expired)
    );

    pbs_frame_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) i_shifter (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (shf_load),
        .frame_i      (frame_i),
        .len_i        (len_i),
        .pop_i        (shf_pop),
        .bit_o        (shf_bit),
        .more_o       (shf_more),
        .load_empty_o (shf_load_empty)
    );

    // Duration capture at the accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_len_q   <= '0;
            one_rest_q  <= '0;
            zero_rest_q <= '0;
        end else if (accept) begin
            gap_len_q   <= pause_ticks_i;
            one_rest_q  <= one_ticks_i - pause_ticks_i;
            zero_rest_q <= zero_ticks_i - pause_ticks_i;
        end
    end

    // Next-state and control decode
    always_comb begin
        state_d  = state_q;
        tmr_arm  = 1'b0;
        tmr_adv  = 1'b0;
        tmr_dur  = '0;
        shf_load = 1'b0;
        shf_pop  = 1'b0;
        done_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    shf_load = 1'b1;
                    tmr_arm  = 1'b1;
                    tmr_dur  = pause_ticks_i;
                    state_d  = shf_load_empty ? ST_EOF : ST_PAUSE;
                end
            end
            ST_PAUSE: begin
                if (tmr_expired) begin
                    tmr_adv = 1'b1;
                    tmr_dur = shf_bit ? one_rest_q : zero_rest_q;
                    state_d = ST_CARRIER;
                end
            end
            ST_CARRIER: begin
                if (tmr_expired) begin
                    shf_pop = 1'b1;
                    tmr_adv = 1'b1;
                    tmr_dur = gap_len_q;
                    state_d = shf_more ? ST_PAUSE : ST_EOF;
                end
            end
            ST_EOF: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_o <= 1'b0;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            pause_o <= (state_d == ST_PAUSE) || (state_d == ST_EOF);
            busy_o  <= (state_d != ST_IDLE);
            done_o  <= done_d;
        end
    end

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic pause_o,
    input logic busy_o,
    input logic done_o
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !pause_o);

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && pause_o));

    assert_close_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(pause_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind pause_bit_sender pbs_checker i_pbs_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .pause_o (pause_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/test_pause_bit_sender.sv
module test_pause_bit_sender;

    localparam int MAX_BITS = 32;
    localparam int CNT_W    = 16;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic [MAX_BITS-1:0] frame_i = '0;
    logic [LEN_W-1:0]    len_i = '0;
    logic [CNT_W-1:0]    pause_ticks_i = 16'd3;
    logic [CNT_W-1:0]    one_ticks_i = 16'd8;
    logic [CNT_W-1:0]    zero_ticks_i = 16'd5;
    logic                pause_o, busy_o, done_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    finished = 1'b0;
    bit    cur_busy = 1'b0;
    string scen = "R1 reset";

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    pause_bit_sender #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) i_pause_bit_sender (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
        .len_i(len_i), .pause_ticks_i(pause_ticks_i), .one_ticks_i(one_ticks_i),
        .zero_ticks_i(zero_ticks_i), .pause_o(pause_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic void push(logic [2:0] v, string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endfunction

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
    end

    // Reference model: expected output sequence built when a start is accepted
    always @(posedge clk) begin : model_b
        int n;
        int p;
        int t;
        if (rst_n && start_i && !cur_busy) begin
            n = (int'(len_i) > MAX_BITS) ? MAX_BITS : int'(len_i);
            p = int'(pause_ticks_i);
            for (int k = 0; k < n; k++) begin
                t = frame_i[k] ? int'(one_ticks_i) : int'(zero_ticks_i);
                repeat (p) push(3'b110, "R2");
                repeat (t - p) push(3'b010, "R3");
            end
            repeat (p) push(3'b110, (n == 0) ? "R6" : "R5");
            push(3'b001, "R7");
        end
    end

    always @(negedge clk) begin : cmp_b
        logic [2:0] e;
        string      t;
        if (!rst_n) begin
            checks++;
            if ({pause_o, busy_o, done_o} !== 3'b000) begin
                errors++;
                $display("FAIL R1 in reset: got pause/busy/done=%b expected 000",
                         {pause_o, busy_o, done_o});
            end
        end else begin
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = 3'b000;
                t = "R1";
            end
            cur_busy = e[1];
            checks++;
            if ({pause_o, busy_o, done_o} !== e) begin
                errors++;
                $display("FAIL %s [%s] cycle %0d: got pause/busy/done=%b expected %b",
                         t, scen, cyc, {pause_o, busy_o, done_o}, e);
            end
        end
    end

    task automatic send(input logic [MAX_BITS-1:0] f, input int n);
        @(posedge clk);
        #2;
        frame_i = f;
        len_i   = LEN_W'(n);
        start_i = 1'b1;
        @(posedge clk);
        #2;
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic durations(input int p, input int one, input int zero);
        pause_ticks_i = CNT_W'(p);
        one_ticks_i   = CNT_W'(one);
        zero_ticks_i  = CNT_W'(zero);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog_b
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog: got run still active expected finished");
            finish_run();
        end
    end

    initial begin : stim_b
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (5) @(posedge clk);

        scen = "R2 R3 mixed byte";
        send(32'h0000_00A5, 8);
        wait_idle();

        scen = "R6 zero length";
        send(32'hFFFF_FFFF, 0);
        wait_idle();

        scen = "R4 upper bits ignored";
        send(32'hFFFF_FFF0, 4);
        wait_idle();

        scen = "R4 length clamp";
        send(32'h8000_0001, 45);
        wait_idle();

        scen = "R8 start while busy";
        send(32'h0000_0003, 3);
        repeat (6) @(posedge clk);
        #2 frame_i = 32'h0000_00FF; len_i = 6'd8; start_i = 1'b1;
        repeat (3) @(posedge clk);
        #2 start_i = 1'b0;
        wait_idle();

        scen = "R9 inputs changed mid-frame";
        send(32'h0000_0036, 6);
        repeat (4) @(posedge clk);
        #2 frame_i = 32'hFFFF_FFFF; len_i = 6'd20; durations(7, 20, 11);
        wait_idle();
        durations(3, 8, 5);

        scen = "R7 start held into done cycle";
        @(posedge clk);
        #2 frame_i = 32'h0000_0002; len_i = 6'd2; start_i = 1'b1;
        @(negedge clk);
        while (!done_o) @(negedge clk);
        @(posedge clk);
        #2 start_i = 1'b0;
        wait_idle();

        scen = "R3 shortest durations";
        durations(1, 2, 3);
        send(32'h0000_0359, 12);
        wait_idle();

        scen = "R3 equal one and zero periods";
        durations(2, 6, 6);
        send(32'h0000_5A5A, 16);
        wait_idle();

        scen = "R10 frames across time-base wrap";
        durations(37, 250, 160);
        while (cyc < 65000) @(posedge clk);
        for (int r = 0; r < 6; r++) begin
            send(32'hDEAD_BEEF ^ MAX_BITS'(r), 32);
            wait_idle();
        end

        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule